// File: doc/BRIEF.md
# Password-Gated Watchdog Reset Controller

This block sits on a simple register bus and lets software force a full chip reset by arming a countdown. Software sets a two-bit reset-type field in a control register, then loads a nonzero count. The count then falls by one on every watchdog tick. A parameterised prescaler derives those ticks from the system clock. When the count reaches zero with the full-reset type selected, the block raises `reset_req` for a fixed number of system clocks and records the cause in a status register.

Every write must carry the byte 0x5A in bits 31:24. Writes without it change nothing, which guards against stray stores. Rewriting the count before it runs out reloads it. This is how software kicks the watchdog. Writing a count of zero disarms it.

Top module: `wdog_rst_ctrl`

## Requirements
- R1: A write whose bits 31:24 differ from 0x5A is dropped, and no register changes.
- R2: The control register is at byte address 0x1C, the status register at 0x20 and the count register at 0x24. Reads of any other address return 0, and writes to other addresses have no effect.
- R3: The control register stores write bits 23:0 and reads back with bits 31:24 as zero. Its reset-type field is bits 5:4, and the other stored bits survive a read-modify-write that changes only that field.
- R4: The count register stores write bits 19:0. Reads return the remaining count with bits 31:20 as zero.
- R5: A watchdog tick occurs once every TICK_DIV system clocks. On each tick the count falls by one while the reset-type field is nonzero and the count is nonzero.
- R6: While the reset-type field is 2'b00 or the count is zero, the count holds. Writing a count of zero disarms the watchdog.
- R7: When the count reaches zero under reset type 2'b10, `reset_req` goes high on the next clock and stays high for exactly PULSE_LEN clocks.
- R8: The status register bits 1:0 read 2'b10 after a full-reset expiry and keep that value afterwards.
- R9: Expiry under reset type 2'b01 or 2'b11 only leaves the count at zero: `reset_req` stays low and the status register is unchanged.
- R10: A valid count write reloads the count immediately and wins over a tick in the same clock.
- R11: After reset all registers read zero and `reset_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Write byte address |
| bus_wdata | input | 32 | Write data, with the password in bits 31:24 |
| bus_raddr | input | 8 | Read byte address |
| bus_rdata | output | 32 | Read data for `bus_raddr` (combinational) |
| reset_req | output | 1 | Full-reset request pulse |

## Verification
The hardest case to reach is a reserved reset type letting the count run all the way to zero. The bench must then show that no pulse appears and that the status register still holds its post-reset value. So the reserved-type runs come before any full-reset expiry, while the status register is still zero. A behavioural model tracks the prescaler phase, so the count and the exact cycle of the pulse are compared on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] WR_KEY   = 8'h5A;
  localparam logic [7:0] OFF_CTRL = 8'h1C;
  localparam logic [7:0] OFF_STAT = 8'h20;
  localparam logic [7:0] OFF_CNT  = 8'h24;
  localparam int         ADDR_W   = 8;
  localparam int         CTRL_W   = 24;
  localparam int         KIND_LSB = 4;

  typedef enum logic [1:0] {
    RK_NONE = 2'b00,
    RK_RSV1 = 2'b01,
    RK_FULL = 2'b10,
    RK_RSV3 = 2'b11
  } rst_kind_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int TICK_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] ph_q, ph_d;

      always_comb begin
        if (ph_q == LAST) ph_d = '0;
        else              ph_d = ph_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
      end

      assign tick = (ph_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_val,
  output logic [CTRL_W-1:0] ctrl_q,
  output rst_kind_e         kind
);
  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_d;
  end

  assign kind = rst_kind_e'(ctrl_q[KIND_LSB +: 2]);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  rst_kind_e        kind,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_d;
  logic             step;

  assign step = tick && (kind != RK_NONE) && (cnt_q != '0);

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (step) begin
      cnt_d  = cnt_q - 1'b1;
      expire = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load || step)   cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
  import wdog_pkg::*;
#(
  parameter int PULSE_LEN = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      expire,
  input  rst_kind_e kind,
  output logic      req,
  output logic [1:0] cause_q
);
  localparam int PLW = $clog2(PULSE_LEN + 1);
  localparam logic [PLW-1:0] PLEN = PLW'(PULSE_LEN);

  logic [PLW-1:0] left_q, left_d;
  logic [1:0]     cause_d;
  logic           fire;

  assign fire = expire && (kind == RK_FULL);

  always_comb begin
    left_d  = left_q;
    cause_d = cause_q;
    if (fire) begin
      left_d  = PLEN;
      cause_d = kind;
    end else if (left_q != '0) begin
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      cause_q <= '0;
    end else begin
      left_q <= left_d;
      if (fire) cause_q <= cause_d;
    end
  end

  assign req = (left_q != '0);
endmodule

// File: rtl/wdog_rst_ctrl.sv
module wdog_rst_ctrl
  import wdog_pkg::*;
#(
  parameter int TICK_DIV  = 16,
  parameter int PULSE_LEN = 8,
  parameter int CNT_W     = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [7:0]  bus_raddr,
  output logic [31:0] bus_rdata,
  output logic        reset_req
);
  logic              key_ok;
  logic              ctrl_wr_ok;
  logic              cnt_wr_ok;
  logic              tick;
  logic              expire;
  rst_kind_e         kind;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        cause_q;

  assign key_ok     = bus_wr && (bus_wdata[31:24] == WR_KEY);
  assign ctrl_wr_ok = key_ok && (bus_addr == OFF_CTRL);
  assign cnt_wr_ok  = key_ok && (bus_addr == OFF_CNT);

  wdog_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  wdog_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ctrl_wr_ok),
    .wr_val(bus_wdata[CTRL_W-1:0]),
    .ctrl_q(ctrl_q),
    .kind  (kind)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_wr_ok),
    .load_val(bus_wdata[CNT_W-1:0]),
    .tick    (tick),
    .kind    (kind),
    .cnt_q   (cnt_q),
    .expire  (expire)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire),
    .kind   (kind),
    .req    (reset_req),
    .cause_q(cause_q)
  );

  always_comb begin
    case (bus_raddr)
      OFF_CTRL: bus_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
      OFF_STAT: bus_rdata = {30'd0, cause_q};
      OFF_CNT:  bus_rdata = {{(32-CNT_W){1'b0}}, cnt_q};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_rst_ctrl_chk.sv
module wdog_rst_ctrl_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [31:0]      bus_wdata,
  input logic [23:0]      ctrl_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             cnt_wr_ok,
  input logic [1:0]       cause_q,
  input logic             reset_req
);
  AST_PW_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[31:24] != 8'h5A) |=> $stable(ctrl_q)); // R1

  AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr_ok |=> (cnt_q <= $past(cnt_q))); // R5

  AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr_ok && ctrl_q[5:4] == 2'b00) |=> $stable(cnt_q)); // R6

  AST_REQ_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> ($past(ctrl_q[5:4]) == 2'b10)); // R7

  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> (cause_q == 2'b10)); // R8
endmodule

bind wdog_rst_ctrl wdog_rst_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .ctrl_q   (ctrl_q),
  .cnt_q    (cnt_q),
  .cnt_wr_ok(cnt_wr_ok),
  .cause_q  (cause_q),
  .reset_req(reset_req)
);

// File: tb/wdog_rst_ctrl_tb.sv
module wdog_rst_ctrl_tb;
  localparam int DIV  = 4;
  localparam int PLEN = 6;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [7:0]  bus_raddr;
  logic [31:0] bus_rdata;
  logic        reset_req;

  int n_tests;
  int n_fail;
  bit done;

  wdog_rst_ctrl #(.TICK_DIV(DIV), .PULSE_LEN(PLEN), .CNT_W(20)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .reset_req(reset_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference state
  int        m_pre;
  int        m_cnt;
  int        m_ctrl;
  int        m_cause;
  int        m_left;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_ctrl = 0; m_cause = 0; m_left = 0;
    end else begin
      bit tk, ok, exp_now;
      int kind;
      tk = (m_pre == DIV - 1);
      m_pre = tk ? 0 : m_pre + 1;
      ok = bus_wr && (bus_wdata[31:24] == 8'h5A);
      kind = (m_ctrl >> 4) & 3;
      exp_now = 0;
      if (ok && bus_addr == 8'h24) m_cnt = bus_wdata & 32'h000F_FFFF;
      else if (tk && kind != 0 && m_cnt != 0) begin
        m_cnt = m_cnt - 1;
        exp_now = (m_cnt == 0);
      end
      if (ok && bus_addr == 8'h1C) m_ctrl = bus_wdata & 32'h00FF_FFFF;
      if (exp_now && kind == 2) begin
        m_left = PLEN; m_cause = 2;
      end else if (m_left > 0) m_left = m_left - 1;
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h1C:   return 32'(m_ctrl);
      8'h20:   return 32'(m_cause);
      8'h24:   return 32'(m_cnt);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R7 reset_req vs model", {31'd0, reset_req}, {31'd0, m_left != 0});
      case (bus_raddr)
        8'h1C:   check("R3 ctrl vs model", bus_rdata, m_read(bus_raddr));
        8'h20:   check("R8 status vs model", bus_rdata, m_read(bus_raddr));
        8'h24:   check("R4 count vs model", bus_rdata, m_read(bus_raddr));
        default: check("R2 unmapped vs model", bus_rdata, m_read(bus_raddr));
      endcase
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 32'd0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_raddr = a;
    @(posedge clk);
    #2;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v, c0, c1;
    int hi, seen;
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; bus_raddr = 8'h24;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11 reset state
    rd(8'h1C, v); check("R11 ctrl after reset", v, 32'd0);
    rd(8'h24, v); check("R11 count after reset", v, 32'd0);
    rd(8'h20, v); check("R11 status after reset", v, 32'd0);
    check("R11 reset_req after reset", {31'd0, reset_req}, 32'd0);

    // R1 bad key
    wr(8'h1C, 32'h1200_0020); rd(8'h1C, v); check("R1 ctrl bad key", v, 32'd0);
    wr(8'h24, 32'hA500_0010); rd(8'h24, v); check("R1 count bad key", v, 32'd0);

    // R3 store, read back, read-modify-write of the kind field
    wr(8'h1C, 32'h5A12_34A3); rd(8'h1C, v); check("R3 ctrl readback", v, 32'h0012_34A3);
    wr(8'h1C, (32'h5A00_0000 | (v & 32'hFFFF_FFCF))); rd(8'h1C, v);
    check("R3 ctrl rmw keeps bits", v, 32'h0012_3483);

    // R2 unmapped address
    wr(8'h10, 32'h5A00_00FF); rd(8'h10, v); check("R2 unmapped read", v, 32'd0);
    rd(8'h1C, v); check("R2 unmapped write no effect", v, 32'h0012_3483);

    // R4 / R6 count held with kind 00
    wr(8'h24, 32'h5AFF_FFFF); rd(8'h24, v); check("R4 count width", v, 32'h000F_FFFF);
    repeat (40) @(posedge clk);
    rd(8'h24, v); check("R6 frozen with kind 00", v, 32'h000F_FFFF);

    // R9 reserved kinds run to zero without a pulse
    for (int k = 0; k < 2; k++) begin
      seen = 0;
      wr(8'h1C, (k == 0) ? 32'h5A00_0013 : 32'h5A00_0033);
      wr(8'h24, 32'h5A00_0005);
      for (int i = 0; i < 60; i++) begin
        @(posedge clk); #1; if (reset_req) seen++;
      end
      rd(8'h24, v); check("R9 reserved count zero", v, 32'd0);
      rd(8'h20, v); check("R9 reserved status kept", v, 32'd0);
      check("R9 reserved no pulse", 32'(seen), 32'd0);
    end

    // R5 rate: a 40-clock window holds exactly 10 ticks
    wr(8'h1C, 32'h5A00_0020);
    wr(8'h24, 32'h5A00_0064);
    rd(8'h24, c0);
    repeat (39) @(posedge clk);
    rd(8'h24, c1);
    check("R5 ten ticks in forty clocks", c0 - c1, 32'd10);

    // R10 kick
    wr(8'h24, 32'h5A00_0064); rd(8'h24, v); check("R10 kick reloads", v, 32'd100);

    // R6 disarm by zero
    wr(8'h24, 32'h5A00_0000);
    seen = 0;
    for (int i = 0; i < 80; i++) begin
      @(posedge clk); #1; if (reset_req) seen++;
    end
    check("R6 disarmed no pulse", 32'(seen), 32'd0);

    // R7 / R8 full-reset expiry
    wr(8'h24, 32'h5A00_000A);
    seen = 0;
    while (!reset_req && seen < 200) begin @(posedge clk); #1; seen++; end
    hi = 0;
    while (reset_req && hi < 50) begin hi++; @(posedge clk); #1; end
    check("R7 pulse width", 32'(hi), 32'(PLEN));
    rd(8'h20, v); check("R8 status full", v, 32'd2);
    repeat (20) @(posedge clk);
    rd(8'h20, v); check("R8 status kept", v, 32'd2);
    rd(8'h24, v); check("R7 count zero after expiry", v, 32'd0);

    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule